// File: doc/BRIEF.md
# Indexed Block-Transfer Register Target for a Two-Wire Management Bus

This block is the target side of a two-wire management bus. It lets a host reach a small file of byte-wide configuration registers. The block oversamples the bus clock and data lines with the core clock. It pulls the data line low through an output enable and never drives it high.

Every transfer starts with an index that selects the first location. A write then gives an explicit byte count, followed by that many data bytes. A read sets the index with a short write, issues a repeated start, and sends the read address. The target then returns the value held at location 8 as a count byte, followed by data starting at the chosen index.

The surrounding logic sees every stored byte at all times on a flat parallel vector.

Top module: `smb_blkreg_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read). Bits [7:1] of the address byte equal 0x69 and bit 0 is 1 for a read. The acknowledge pulls SDA low for the whole ninth SCL high period.
- R2: For any other address byte, the target does not acknowledge. SDA then stays released through all further bus activity until the next start condition.
- R3: A block write carries an index N, then a count X, then X data bytes. The bytes are stored at N, N+1, and onward, and the target acknowledges each byte.
- R4: A data byte that arrives after the X counted bytes is not acknowledged and is not stored.
- R5: After a read address, the target sends the byte at location 8 first, then the bytes from index N onward. Each byte goes MSB first. SDA changes only while SCL is low, apart from a release on a start or stop.
- R6: When the host answers a sent byte with NACK, the target releases SDA. SDA stays released, even under further SCL pulses, until the next start.
- R7: The location pointer wraps from 31 to 0 on both writes and reads.
- R8: A starting index of 32 or more is acknowledged, but writes through it are discarded and reads through it return 0x00.
- R9: A start or stop condition aborts any transfer and releases SDA. A start always begins a new address phase. Bytes already stored stay stored.
- R10: After reset, every location reads 0x00 and SDA is released.
- R11: Output bits [8i+7:8i] of `regs_flat` hold location i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_flat | output | NREGS*8 | All register locations, location i at bits [8i+7:8i] |

## Verification
On every cycle, the assertions check four things:
- SDA is never pulled or released while the synchronised SCL is high, except for a release on a start or stop.
- Every start or stop leaves SDA released.
- The target is silent while it ignores the bus or sits idle.
- No write reaches the file through an out-of-range pointer.

Only the bench scenarios can show the byte-level behaviour:
- the address match;
- the count byte taken from location 8;
- pointer wrap and discarded writes;
- rejection of bytes beyond the count;
- resumption after an aborted transfer.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_HACK,
      PH_IGNORE
   } phase_e;

   typedef enum logic [1:0] {
      RK_ADDR,
      RK_INDEX,
      RK_COUNT,
      RK_DATA
   } rxkind_e;
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_bus_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
   parameter int NREGS   = 32,
   parameter int CNT_IDX = 8,
   localparam int AW     = $clog2(NREGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [7:0]         wdata,
   input  logic [AW-1:0]      raddr,
   output logic [7:0]         rdata,
   output logic [7:0]         cnt_val,
   output logic [NREGS*8-1:0] regs_flat
);
   for (genvar i = 0; i < NREGS; i++) begin : g_row
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && waddr == AW'(i))
            q <= wdata;
      end
      assign regs_flat[8*i +: 8] = q;
   end

   assign rdata   = regs_flat[{raddr, 3'b000} +: 8];
   assign cnt_val = regs_flat[8*CNT_IDX +: 8];
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_blk_pkg::*;
#(
   parameter logic [6:0] ADDR7 = 7'h69,
   parameter int         NREGS = 32,
   localparam int        AW    = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_s,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [7:0]    rdata,
   input  logic [7:0]    cnt_val,
   output logic          sda_oe,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [7:0]    wdata,
   output logic [AW-1:0] raddr,
   output phase_e        phase_o,
   output logic [7:0]    ptr_o
);
   localparam logic [8:0] NREGS_W = 9'(NREGS);

   phase_e        phase;
   rxkind_e       kind;
   logic [3:0]    bitcnt;
   logic [7:0]    shreg, txbyte, ptr, remain;
   logic          ack_on, tx_next, host_ack;
   logic [7:0]    rx_byte, rd_byte, ptr_next;
   logic          ptr_ok;
   logic [AW-1:0] idx_inc;

   assign rx_byte  = {shreg[6:0], sda_s};
   assign ptr_ok   = {1'b0, ptr} < NREGS_W;
   assign idx_inc  = ptr[AW-1:0] + 1'b1;
   assign ptr_next = ptr_ok ? 8'(idx_inc) : ptr;
   assign rd_byte  = ptr_ok ? rdata : 8'h00;
   assign raddr    = ptr[AW-1:0];
   assign phase_o  = phase;
   assign ptr_o    = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         kind     <= RK_ADDR;
         bitcnt   <= '0;
         shreg    <= '0;
         txbyte   <= '0;
         ptr      <= '0;
         remain   <= '0;
         sda_oe   <= 1'b0;
         ack_on   <= 1'b0;
         tx_next  <= 1'b0;
         host_ack <= 1'b0;
         we       <= 1'b0;
         waddr    <= '0;
         wdata    <= '0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            phase  <= PH_RX;
            kind   <= RK_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            ack_on <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
            ack_on <= 1'b0;
         end else begin
            unique case (phase)
               PH_RX: if (scl_rise) begin
                  shreg <= rx_byte;
                  if (bitcnt == 4'd7) begin
                     bitcnt  <= '0;
                     phase   <= PH_ACK;
                     tx_next <= 1'b0;
                     unique case (kind)
                        RK_ADDR: begin
                           if (rx_byte[7:1] != ADDR7) begin
                              phase <= PH_IGNORE;
                           end else if (rx_byte[0]) begin
                              tx_next <= 1'b1;
                              txbyte  <= cnt_val;
                           end else begin
                              kind <= RK_INDEX;
                           end
                        end
                        RK_INDEX: begin
                           ptr  <= rx_byte;
                           kind <= RK_COUNT;
                        end
                        RK_COUNT: begin
                           remain <= rx_byte;
                           kind   <= RK_DATA;
                        end
                        RK_DATA: begin
                           if (remain == 8'd0) begin
                              phase <= PH_IGNORE;
                           end else begin
                              remain <= remain - 1'b1;
                              ptr    <= ptr_next;
                              if (ptr_ok) begin
                                 we    <= 1'b1;
                                 waddr <= ptr[AW-1:0];
                                 wdata <= rx_byte;
                              end
                           end
                        end
                        default: ;
                     endcase
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               PH_ACK: if (scl_fall) begin
                  if (!ack_on) begin
                     sda_oe <= 1'b1;
                     ack_on <= 1'b1;
                  end else begin
                     ack_on <= 1'b0;
                     bitcnt <= '0;
                     if (tx_next) begin
                        phase  <= PH_TX;
                        sda_oe <= ~txbyte[7];
                     end else begin
                        phase  <= PH_RX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_HACK;
                     end else begin
                        txbyte <= {txbyte[6:0], 1'b0};
                        sda_oe <= ~txbyte[6];
                     end
                  end
               end
               PH_HACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        txbyte <= rd_byte;
                        ptr    <= ptr_next;
                        bitcnt <= '0;
                        phase  <= PH_TX;
                        sda_oe <= ~rd_byte[7];
                     end else begin
                        phase <= PH_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target
   import smb_blk_pkg::*;
#(
   parameter logic [6:0] ADDR7       = 7'h69,
   parameter int         NREGS       = 32,
   parameter int         CNT_IDX     = 8,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW          = $clog2(NREGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   output logic [NREGS*8-1:0] regs_flat
);
   if (NREGS < 2 || NREGS > 128 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("smb_blkreg_target: NREGS must be a power of two from 2 to 128");
   end
   if (CNT_IDX < 0 || CNT_IDX >= NREGS) begin : g_bad_cnt
      $error("smb_blkreg_target: CNT_IDX must address a location inside the file");
   end

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          reg_we;
   logic [AW-1:0] waddr, raddr;
   logic [7:0]    wdata, rdata, cnt_val, ptr_q;
   phase_e        phase;

   smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_proto_fsm #(.ADDR7(ADDR7), .NREGS(NREGS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rdata     (rdata),
      .cnt_val   (cnt_val),
      .sda_oe    (sda_oe),
      .we        (reg_we),
      .waddr     (waddr),
      .wdata     (wdata),
      .raddr     (raddr),
      .phase_o   (phase),
      .ptr_o     (ptr_q)
   );

   smb_regfile #(.NREGS(NREGS), .CNT_IDX(CNT_IDX)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .waddr     (waddr),
      .wdata     (wdata),
      .raddr     (raddr),
      .rdata     (rdata),
      .cnt_val   (cnt_val),
      .regs_flat (regs_flat)
   );
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk
   import smb_blk_pkg::*;
#(
   parameter int NREGS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic       sda_oe,
   input phase_e     phase,
   input logic       reg_we,
   input logic [7:0] ptr_q
);
   // R5: the data line only moves while the synchronised clock is low
   p_oe_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

   // R9: start and stop both leave the line released
   p_release_on_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_oe);

   // R2 and R6: silent while ignoring the bus or idle
   p_quiet_when_ignoring_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGNORE || phase == PH_IDLE) |-> !sda_oe);

   // R8: a file write only ever comes from an in-range pointer
   p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> ($past(ptr_q) < 8'(NREGS)));
endmodule

bind smb_blkreg_target smb_blkreg_chk #(.NREGS(NREGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe),
   .phase     (phase),
   .reg_we    (reg_we),
   .ptr_q     (ptr_q)
);

// File: tb/smb_blkreg_target_tb.sv
module smb_blkreg_target_tb;
   localparam int NREGS = 32;
   localparam int Q     = 100;
   localparam int NVEC  = 5;
   // index, count, first data byte, step between data bytes
   localparam logic [31:0] VEC [NVEC] = '{
      32'h00_04_11_11,
      32'h08_01_03_00,
      32'h1E_04_A0_01,
      32'h0C_03_5A_33,
      32'h28_02_EE_01
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [NREGS*8-1:0] regs_flat;
   logic [7:0] model [NREGS];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;
   assign sda_line = host_sda & ~sda_oe;

   smb_blkreg_target u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (host_scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .regs_flat (regs_flat)
   );

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [NREGS*8-1:0] model_flat();
      logic [NREGS*8-1:0] f;
      for (int i = 0; i < NREGS; i++) f[8*i +: 8] = model[i];
      return f;
   endfunction

   task automatic chk_file(input string req);
      checks++;
      if (regs_flat !== model_flat()) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, regs_flat, model_flat());
      end
   endtask

   function automatic logic [7:0] step_ptr(input logic [7:0] p);
      return (p < NREGS) ? 8'((p + 1) % NREGS) : p;
   endfunction

   task automatic bus_start();
      host_sda = 1'b1; host_scl = 1'b1; #Q;
      host_sda = 1'b0; #Q;
      host_scl = 1'b0; #Q;
   endtask

   task automatic bus_rstart();
      host_sda = 1'b1; #Q;
      host_scl = 1'b1; #Q;
      host_sda = 1'b0; #Q;
      host_scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; #Q;
      host_scl = 1'b1; #Q;
      host_sda = 1'b1; #Q;
   endtask

   task automatic wr_bit(input logic b);
      host_sda = b; #Q;
      host_scl = 1'b1; #(2*Q);
      host_scl = 1'b0; #Q;
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) wr_bit(d[i]);
      host_sda = 1'b1; #Q;
      host_scl = 1'b1; #Q;
      ack = ~sda_line; #Q;
      host_scl = 1'b0; #Q;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] d);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #Q; host_scl = 1'b1;
         #Q; d[i] = sda_line;
         #Q; host_scl = 1'b0;
         #Q;
      end
      wr_bit(~give_ack);
   endtask

   initial begin
      logic ack;
      logic [7:0] d, idx, cnt, base, stp, p;
      string tag;
      for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
      #20; rst_n = 1'b1; #40;

      // R10: reset state
      chk8("R10 sda released", {7'd0, sda_oe}, 8'd0);
      chk_file("R10 file cleared");

      for (int v = 0; v < NVEC; v++) begin
         idx = VEC[v][31:24]; cnt = VEC[v][23:16];
         base = VEC[v][15:8]; stp = VEC[v][7:0];
         tag = (idx >= NREGS) ? "R8" : ((idx + cnt > NREGS) ? "R7" : "R3");
         bus_start();
         wr_byte(8'hD2, ack); chk8("R1 write address ack", {7'd0, ack}, 8'd1);
         wr_byte(idx, ack);   chk8("R3 index ack", {7'd0, ack}, 8'd1);
         wr_byte(cnt, ack);   chk8("R3 count ack", {7'd0, ack}, 8'd1);
         p = idx;
         for (int k = 0; k < cnt; k++) begin
            d = 8'(base + k * stp);
            wr_byte(d, ack);
            chk8({tag, " data ack"}, {7'd0, ack}, 8'd1);
            if (p < NREGS) model[p] = d;
            p = step_ptr(p);
         end
         bus_stop(); #Q;
         chk_file({"R11 ", tag, " file contents"});

         bus_start();
         wr_byte(8'hD2, ack);
         wr_byte(idx, ack);
         bus_rstart();
         wr_byte(8'hD3, ack); chk8("R1 read address ack", {7'd0, ack}, 8'd1);
         rd_byte(1'b1, d);    chk8("R5 count byte from location 8", d, model[8]);
         p = idx;
         for (int k = 0; k < cnt; k++) begin
            rd_byte(k != cnt - 1, d);
            chk8({(tag == "R3") ? "R5" : tag, " read data"}, d, (p < NREGS) ? model[p] : 8'h00);
            p = step_ptr(p);
         end
         bus_stop(); #Q;
      end

      // R2: foreign address is never acknowledged, later bytes ignored
      bus_start();
      wr_byte(8'hA4, ack); chk8("R2 foreign address nack", {7'd0, ack}, 8'd0);
      wr_byte(8'h00, ack); chk8("R2 later byte nack", {7'd0, ack}, 8'd0);
      bus_stop(); #Q;
      chk_file("R2 file untouched");

      // R4: byte beyond count rejected
      bus_start();
      wr_byte(8'hD2, ack); wr_byte(8'd20, ack); wr_byte(8'd1, ack);
      wr_byte(8'h77, ack); chk8("R4 counted byte ack", {7'd0, ack}, 8'd1);
      model[20] = 8'h77;
      wr_byte(8'h88, ack); chk8("R4 extra byte nack", {7'd0, ack}, 8'd0);
      bus_stop(); #Q;
      chk_file("R4 extra byte not stored");

      // R9: stop mid transfer keeps stored bytes, start mid byte restarts
      bus_start();
      wr_byte(8'hD2, ack); wr_byte(8'd5, ack); wr_byte(8'd2, ack);
      wr_byte(8'h99, ack); model[5] = 8'h99;
      bus_stop(); #Q;
      chk8("R9 released after stop", {7'd0, sda_oe}, 8'd0);
      chk_file("R9 partial transfer kept");
      bus_start();
      wr_byte(8'hD2, ack);
      wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
      bus_rstart();
      wr_byte(8'hD2, ack); chk8("R9 address after restart ack", {7'd0, ack}, 8'd1);
      wr_byte(8'd6, ack); wr_byte(8'd1, ack); wr_byte(8'h42, ack);
      model[6] = 8'h42;
      bus_stop(); #Q;
      chk_file("R9 transfer after restart");

      // R6: NACK releases the line for all further clocks
      bus_start();
      wr_byte(8'hD2, ack); wr_byte(8'd0, ack);
      bus_rstart();
      wr_byte(8'hD3, ack);
      rd_byte(1'b1, d);
      rd_byte(1'b0, d); chk8("R6 last byte before nack", d, model[0]);
      rd_byte(1'b0, d); chk8("R6 line released after nack", d, 8'hFF);
      bus_stop(); #Q;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule